// File: doc/BRIEF.md
# Control-Structure Field Access Unit

This unit serves read and write commands aimed at a small on-chip table of control fields. A command names a field by a 64-bit encoding. The unit runs a fixed chain of checks:

1. Is the requester a guest?
2. Is its privilege level non-zero?
3. Is the current-structure pointer valid?
4. Does the encoding name a field in the table?
5. For a write, is the field read-only?

Only a command that passes every check touches the table. Every command gets exactly one registered response. The response carries an outcome, an error number, the arithmetic status flags that the outcome implies and, for a successful read, the field data.

Operand sizing depends on the mode flag: the operand is 32 bits wide outside 64-bit mode and 64 bits wide inside it. Each field also has its own width class, which is 16, 32 or 64 bits, or a natural width that follows the mode. Reads and writes treat a mismatch between the two widths differently:

- **Reads:** the field is zero-extended or cut to the operand width.
- **Writes:** operand bits above the field width are dropped, and field bits above the operand width are cleared.

Top module: `cfa_field_unit`

## Requirements
- R1: A command presented with `cmd_valid` high at a rising edge produces `rsp_valid` high for exactly the following cycle. With no command, `rsp_valid` stays low.
- R2: The outcome (`rsp_result`) is decided by the first check that fails, in this order:
  - guest mode gives 1 (exit);
  - a privilege level other than 0 gives 2 (fault);
  - an invalid pointer gives 3 (fail-invalid);
  - an unsupported encoding gives 4 (fail-valid, error 12);
  - a write to a read-only field gives 4 (fail-valid, error 13);
  - otherwise the outcome is 0 (success).
- R3: The table has 16 fields. The encoding of field i (i = 0..15) has bits 14:13 equal to i mod 4, bits 8:1 equal to i, bit 10 set when i is 12 or more, and all other bits zero. Encoding bits 14:13 select the width class: 0 is 16 bits, 1 is 64 bits, 2 is 32 bits, and 3 is natural width (equal to the operand width). Bits 11:10 equal to 1 mark the field read-only.
- R4: In 64-bit mode, an encoding with any set bit in 63:32 is unsupported. Outside 64-bit mode, bits 63:32 of the encoding are ignored.
- R5: An encoding whose low 32 bits match no table entry fails-valid with error 12.
- R6: A write to a read-only field fails-valid with error 13, and the field keeps its value.
- R7: A successful read returns the field value limited to the operand width (32 bits outside 64-bit mode, 64 inside), with all higher result bits zero.
- R8: A successful write stores the operand truncated to the smaller of the field width and the operand width. Every higher field bit becomes zero.
- R9: `rsp_flags` bit 0 is CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF and bit 5 OF. Success, exit and fault give all zeros. Fail-invalid gives CF alone (000001). Fail-valid gives ZF alone (001000).
- R10: After reset, field i holds a value in which every 4-bit nibble equals i, cut to the field's width class (natural width counts as 64).
- R11: A response other than a successful read has `rsp_data` zero. `rsp_err` is zero unless the outcome is fail-valid. A command that does not succeed changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write field, 0 = read field |
| cmd_enc | input | 64 | Field encoding operand |
| cmd_data | input | 64 | Write data operand |
| long_mode | input | 1 | 64-bit mode flag |
| priv_lvl | input | 2 | Privilege level of the requester |
| guest_mode | input | 1 | Requester runs as guest |
| ptr_valid | input | 1 | Current control-structure pointer is valid |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_result | output | 3 | Outcome: 0 ok, 1 exit, 2 fault, 3 fail-invalid, 4 fail-valid |
| rsp_err | output | 8 | Error number for fail-valid |
| rsp_flags | output | 6 | Status flags {OF,SF,ZF,AF,PF,CF} |
| rsp_data | output | 64 | Read result |

## Verification
The hardest case to expose is the asymmetric sizing.

- **Natural-width field.** Only a write in 32-bit mode followed by a read in 64-bit mode shows that the upper field bits were cleared rather than kept. The stimulus therefore writes a full 64-bit pattern to every writable field in 32-bit mode, then reads each one back in 64-bit mode. It then repeats the write in 64-bit mode and reads back in both modes.
- **Upper encoding bits.** The same encoding, carrying a set bit above bit 31, is issued in both modes. It must fail in one mode and reach the field in the other.
- **Check order.** Commands that break several checks at once show that the priority chain is honoured.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

   typedef enum logic [2:0] {
      RES_OK       = 3'd0,
      RES_EXIT     = 3'd1,
      RES_FAULT    = 3'd2,
      RES_FAIL_INV = 3'd3,
      RES_FAIL_VAL = 3'd4
   } result_e;

   localparam int OPND_W = 64;
   localparam int CODE_W = 32;

   // Flag bit positions inside the 6-bit flag vector
   localparam int FLG_CF = 0;
   localparam int FLG_ZF = 3;

   function automatic logic [OPND_W-1:0] width_mask(input int bits);
      if (bits >= OPND_W) return '1;
      return (OPND_W'(1) << bits) - OPND_W'(1);
   endfunction

   // Width class decode; class 3 follows the operand width
   function automatic int class_bits(input logic [1:0] cls, input logic lm);
      case (cls)
         2'd0:    return 16;
         2'd1:    return 64;
         2'd2:    return 32;
         default: return lm ? 64 : 32;
      endcase
   endfunction

   // Encoding of table entry idx
   function automatic logic [CODE_W-1:0] field_code(input int idx, input int ro_first);
      logic [CODE_W-1:0] c;
      c        = CODE_W'(idx & 255) << 1;
      c[14:13] = 2'(idx % 4);
      c[10]    = (idx >= ro_first);
      return c;
   endfunction

   // Value of entry idx after reset: nibble pattern cut to class width
   function automatic logic [OPND_W-1:0] reset_value(input int idx, input logic [1:0] cls);
      logic [OPND_W-1:0] v;
      v = '0;
      for (int n = 0; n < OPND_W / 4; n++) v[n*4 +: 4] = 4'(idx);
      return v & width_mask(class_bits(cls, 1'b1));
   endfunction

   function automatic logic [5:0] flags_for(input result_e r);
      logic [5:0] f;
      f = '0;
      if (r == RES_FAIL_INV) f[FLG_CF] = 1'b1;
      if (r == RES_FAIL_VAL) f[FLG_ZF] = 1'b1;
      return f;
   endfunction

endpackage

// File: rtl/cfa_decode.sv
module cfa_decode
   import cfa_pkg::*;
#(
   parameter int NUM_FIELDS = 16,
   parameter int RO_FIRST   = 12,
   parameter int IDX_W      = 4,
   parameter logic [7:0] ERR_UNSUP = 8'd12,
   parameter logic [7:0] ERR_RDONLY = 8'd13
) (
   input  logic [OPND_W-1:0]     enc,
   input  logic                  long_mode,
   input  logic                  is_write,
   input  logic [1:0]            priv,
   input  logic                  guest,
   input  logic                  ptr_ok,
   output result_e               res,
   output logic [7:0]            err,
   output logic [NUM_FIELDS-1:0] hit,
   output logic [IDX_W-1:0]      idx,
   output logic [1:0]            cls
);

   logic upper_bad;
   logic rdonly;
   logic known;

   assign upper_bad = long_mode && (enc[OPND_W-1:CODE_W] != '0);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_match
      localparam logic [CODE_W-1:0] CODE = field_code(i, RO_FIRST);
      assign hit[i] = !upper_bad && (enc[CODE_W-1:0] == CODE);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_FIELDS; i++)
         if (hit[i]) idx = IDX_W'(i);
   end

   assign known  = |hit;
   assign cls    = enc[14:13];
   assign rdonly = (enc[11:10] == 2'b01);

   always_comb begin
      err = '0;
      if (guest)              res = RES_EXIT;
      else if (priv != 2'd0)  res = RES_FAULT;
      else if (!ptr_ok)       res = RES_FAIL_INV;
      else if (!known) begin
         res = RES_FAIL_VAL;
         err = ERR_UNSUP;
      end else if (is_write && rdonly) begin
         res = RES_FAIL_VAL;
         err = ERR_RDONLY;
      end else                res = RES_OK;
   end

endmodule

// File: rtl/cfa_sizer.sv
module cfa_sizer
   import cfa_pkg::*;
(
   input  logic [1:0]        cls,
   input  logic              long_mode,
   input  logic [OPND_W-1:0] wr_in,
   input  logic [OPND_W-1:0] rd_in,
   output logic [OPND_W-1:0] wr_out,
   output logic [OPND_W-1:0] rd_out
);

   int op_bits;
   int fld_bits;
   int keep_bits;

   always_comb begin
      op_bits   = long_mode ? 64 : 32;
      fld_bits  = class_bits(cls, long_mode);
      keep_bits = (fld_bits < op_bits) ? fld_bits : op_bits;
      wr_out    = wr_in & width_mask(keep_bits);
      rd_out    = rd_in & width_mask(op_bits);
   end

endmodule

// File: rtl/cfa_store.sv
module cfa_store
   import cfa_pkg::*;
#(
   parameter int NUM_FIELDS = 16,
   parameter int RO_FIRST   = 12,
   parameter int IDX_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [OPND_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [OPND_W-1:0] rdata
);

   logic [OPND_W-1:0] vals [NUM_FIELDS];

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam logic [CODE_W-1:0] CODE = field_code(i, RO_FIRST);
      localparam logic [OPND_W-1:0] INIT = reset_value(i, CODE[14:13]);
      logic [OPND_W-1:0] q;
      if (i >= RO_FIRST) begin : g_ro
         assign q = INIT;
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= INIT;
            else if (we && widx == IDX_W'(i))   q <= wdata;
         end
      end
      assign vals[i] = q;
   end

   assign rdata = vals[ridx];

   // R6: no write may be aimed at a hardwired entry
   a_r6_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(widx) < RO_FIRST));

endmodule

// File: rtl/cfa_field_unit.sv
module cfa_field_unit
   import cfa_pkg::*;
#(
   parameter int NUM_FIELDS = 16,
   parameter int RO_FIRST   = 12,
   parameter logic [7:0] ERR_UNSUP  = 8'd12,
   parameter logic [7:0] ERR_RDONLY = 8'd13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic        cmd_write,
   input  logic [63:0] cmd_enc,
   input  logic [63:0] cmd_data,
   input  logic        long_mode,
   input  logic [1:0]  priv_lvl,
   input  logic        guest_mode,
   input  logic        ptr_valid,
   output logic        rsp_valid,
   output logic [2:0]  rsp_result,
   output logic [7:0]  rsp_err,
   output logic [5:0]  rsp_flags,
   output logic [63:0] rsp_data
);

   localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

   if (NUM_FIELDS < 2 || NUM_FIELDS > 256) begin : g_bad_count
      $error("cfa_field_unit: NUM_FIELDS must lie in 2..256");
   end
   if (RO_FIRST < 0 || RO_FIRST > NUM_FIELDS) begin : g_bad_ro
      $error("cfa_field_unit: RO_FIRST must lie in 0..NUM_FIELDS");
   end
   if (ERR_UNSUP == ERR_RDONLY) begin : g_bad_err
      $error("cfa_field_unit: error numbers must differ");
   end

   result_e               res;
   logic [7:0]            err;
   logic [NUM_FIELDS-1:0] hit;
   logic [IDX_W-1:0]      idx;
   logic [1:0]            cls;
   logic [OPND_W-1:0]     raw_rd, sized_rd, sized_wr;
   logic                  wr_en;

   cfa_decode #(
      .NUM_FIELDS(NUM_FIELDS), .RO_FIRST(RO_FIRST), .IDX_W(IDX_W),
      .ERR_UNSUP(ERR_UNSUP), .ERR_RDONLY(ERR_RDONLY)
   ) i_decode (
      .enc(cmd_enc), .long_mode(long_mode), .is_write(cmd_write),
      .priv(priv_lvl), .guest(guest_mode), .ptr_ok(ptr_valid),
      .res(res), .err(err), .hit(hit), .idx(idx), .cls(cls)
   );

   cfa_sizer i_sizer (
      .cls(cls), .long_mode(long_mode),
      .wr_in(cmd_data), .rd_in(raw_rd),
      .wr_out(sized_wr), .rd_out(sized_rd)
   );

   assign wr_en = cmd_valid && cmd_write && (res == RES_OK);

   cfa_store #(
      .NUM_FIELDS(NUM_FIELDS), .RO_FIRST(RO_FIRST), .IDX_W(IDX_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(idx), .wdata(sized_wr),
      .ridx(idx), .rdata(raw_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_result <= '0;
         rsp_err    <= '0;
         rsp_flags  <= '0;
         rsp_data   <= '0;
      end else begin
         rsp_valid <= cmd_valid;
         if (cmd_valid) begin
            rsp_result <= res;
            rsp_err    <= err;
            rsp_flags  <= flags_for(res);
            rsp_data   <= (res == RES_OK && !cmd_write) ? sized_rd : '0;
         end
      end
   end

   // R1: one response per command, in the next cycle
   a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);
   // R2: guest mode wins over every other check
   a_r2_exit_first: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && guest_mode |=> rsp_result == 3'(RES_EXIT));
   a_r2_fault_second: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !guest_mode && priv_lvl != 2'd0 |=> rsp_result == 3'(RES_FAULT));
   // R3: an encoding matches at most one entry
   a_r3_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $onehot0(hit));
   // R7: outside 64-bit mode the upper result half is zero
   a_r7_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !long_mode |=> rsp_data[63:32] == 32'd0);
   // R9: flag patterns per outcome
   a_r9_flags_fail_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_result == 3'(RES_FAIL_VAL) |-> rsp_flags == 6'b001000);
   a_r9_flags_fail_inv: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_result == 3'(RES_FAIL_INV) |-> rsp_flags == 6'b000001);
   // R11: no data leaves with a failed command
   a_r11_no_data_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_result != 3'(RES_OK) |-> rsp_data == 64'd0);

endmodule

// File: tb/test_cfa_field_unit.sv
`timescale 1ns/1ps
module test_cfa_field_unit;

   typedef struct {
      logic [2:0]  result;
      logic [7:0]  err;
      logic [5:0]  flags;
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [63:0] cmd_enc = '0, cmd_data = '0;
   logic        long_mode = 1'b0;
   logic [1:0]  priv_lvl = '0;
   logic        guest_mode = 1'b0, ptr_valid = 1'b0;
   logic        rsp_valid;
   logic [2:0]  rsp_result;
   logic [7:0]  rsp_err;
   logic [5:0]  rsp_flags;
   logic [63:0] rsp_data;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t        sb [$];
   logic [63:0] model [16];

   always #4 clk = ~clk;

   cfa_field_unit i_cfa_field_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_enc(cmd_enc), .cmd_data(cmd_data), .long_mode(long_mode),
      .priv_lvl(priv_lvl), .guest_mode(guest_mode), .ptr_valid(ptr_valid),
      .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_err(rsp_err),
      .rsp_flags(rsp_flags), .rsp_data(rsp_data)
   );

   function automatic logic [63:0] enc_of(int i);
      logic [63:0] e;
      e = 64'(i) << 1;
      e = e | (64'(i % 4) << 13);
      if (i >= 12) e = e | 64'h400;
      return e;
   endfunction

   function automatic int bits_of(logic [1:0] c, bit lm);
      case (c)
         2'd0: return 16;
         2'd1: return 64;
         2'd2: return 32;
         default: return lm ? 64 : 32;
      endcase
   endfunction

   function automatic logic [63:0] mask(int b);
      return (b >= 64) ? '1 : ((64'd1 << b) - 64'd1);
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: computes the expected response, updates the model, drives one cycle
   task automatic issue(bit wr, logic [63:0] enc, logic [63:0] d, bit lm,
                        logic [1:0] pl, bit gm, bit pv, string tag);
      exp_t x;
      int   hit_i;
      bit   bad_hi;
      int   op;
      hit_i  = -1;
      bad_hi = lm && (enc[63:32] != 32'd0);
      for (int i = 0; i < 16; i++)
         if (!bad_hi && enc[31:0] == enc_of(i)[31:0]) hit_i = i;
      op = lm ? 64 : 32;
      x.err = 8'd0; x.flags = 6'd0; x.data = 64'd0; x.tag = tag;
      if (gm)                 x.result = 3'd1;
      else if (pl != 2'd0)    x.result = 3'd2;
      else if (!pv) begin     x.result = 3'd3; x.flags = 6'b000001; end
      else if (hit_i < 0) begin x.result = 3'd4; x.err = 8'd12; x.flags = 6'b001000; end
      else if (wr && enc[11:10] == 2'b01) begin
         x.result = 3'd4; x.err = 8'd13; x.flags = 6'b001000;
      end else begin
         x.result = 3'd0;
         if (wr) begin
            int fw;
            int kb;
            fw = bits_of(enc[14:13], lm);
            kb = (fw < op) ? fw : op;
            model[hit_i] = d & mask(kb);
         end else x.data = model[hit_i] & mask(op);
      end
      sb.push_back(x);
      cmd_valid = 1'b1; cmd_write = wr; cmd_enc = enc; cmd_data = d;
      long_mode = lm; priv_lvl = pl; guest_mode = gm; ptr_valid = pv;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Monitor: pops and compares each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) check(1'b0, "R1", "unexpected response", 64'd1, 64'd0);
         else begin
            exp_t x;
            x = sb.pop_front();
            check(rsp_result == x.result && rsp_err == x.err && rsp_flags == x.flags
                  && rsp_data == x.data, x.tag, "result/err/flags/data",
                  {rsp_result, rsp_err, rsp_flags, rsp_data[46:0]},
                  {x.result, x.err, x.flags, x.data[46:0]});
            check(rsp_data == x.data, x.tag, "data", rsp_data, x.data);
         end
      end
   end

   initial begin
      repeat (25000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         logic [63:0] v;
         for (int n = 0; n < 16; n++) v[n*4 +: 4] = 4'(i);
         model[i] = v & mask(bits_of(enc_of(i)[14:13], 1'b1));
      end
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "reset valid", 64'(rsp_valid), 64'd0);
      check(rsp_data == 64'd0 && rsp_flags == 6'd0, "R11", "reset data/flags",
            rsp_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 / R3: reset contents, 64-bit mode
      for (int i = 0; i < 16; i++) issue(0, enc_of(i), 0, 1, 0, 0, 1, "R10");
      // R7: reads outside 64-bit mode
      for (int i = 0; i < 16; i++) issue(0, enc_of(i), 0, 0, 0, 0, 1, "R7");
      // R8: 32-bit-mode writes, read back in 64-bit mode
      for (int i = 0; i < 12; i++) issue(1, enc_of(i), 64'hFEDC_BA98_7654_3210, 0, 0, 0, 1, "R8");
      for (int i = 0; i < 12; i++) issue(0, enc_of(i), 0, 1, 0, 0, 1, "R8");
      // R8: 64-bit-mode writes, read back in both modes
      for (int i = 0; i < 12; i++) issue(1, enc_of(i), 64'h0123_4567_89AB_CDEF, 1, 0, 0, 1, "R8");
      for (int i = 0; i < 12; i++) issue(0, enc_of(i), 0, 1, 0, 0, 1, "R7");
      for (int i = 0; i < 12; i++) issue(0, enc_of(i), 0, 0, 0, 0, 1, "R7");
      // R6: read-only writes rejected, contents kept
      for (int i = 12; i < 16; i++) issue(1, enc_of(i), 64'h5555_AAAA_5555_AAAA, 1, 0, 0, 1, "R6");
      for (int i = 12; i < 16; i++) issue(0, enc_of(i), 0, 1, 0, 0, 1, "R6");
      // R5: unknown encodings
      issue(0, 64'h1, 0, 1, 0, 0, 1, "R5");
      issue(1, 64'h0000_0401, 64'hFF, 1, 0, 0, 1, "R5");
      issue(0, 64'h0000_7FFE, 0, 0, 0, 0, 1, "R5");
      // R4: upper encoding bits
      issue(0, enc_of(3) | 64'h0000_0100_0000_0000, 0, 1, 0, 0, 1, "R4");
      issue(0, enc_of(3) | 64'h0000_0100_0000_0000, 0, 0, 0, 0, 1, "R4");
      issue(1, enc_of(7) | 64'h8000_0000_0000_0000, 64'h77, 0, 0, 0, 1, "R4");
      issue(0, enc_of(7), 0, 1, 0, 0, 1, "R4");
      // R2: check priority
      issue(1, 64'h1, 0, 1, 3, 1, 0, "R2");
      issue(0, enc_of(2), 0, 1, 1, 0, 0, "R2");
      issue(0, 64'h1, 0, 1, 0, 0, 0, "R2");
      issue(1, enc_of(13), 0, 1, 0, 0, 0, "R2");
      issue(1, 64'h0000_0403, 0, 1, 0, 0, 1, "R2");
      // R11: failed writes leave contents alone
      issue(1, enc_of(1), 64'hDEAD_BEEF_DEAD_BEEF, 1, 2, 0, 1, "R11");
      issue(1, enc_of(1), 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 1, 1, "R11");
      issue(1, enc_of(1), 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 0, 0, "R11");
      issue(0, enc_of(1), 0, 1, 0, 0, 1, "R11");
      // R9: flags seen in each outcome above; one more back-to-back mix
      issue(0, enc_of(0), 0, 1, 0, 0, 0, "R9");
      issue(0, enc_of(0), 0, 1, 0, 0, 1, "R9");
      issue(0, 64'h2, 0, 1, 0, 0, 1, "R9");

      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "idle valid", 64'(rsp_valid), 64'd0);
      check(sb.size() == 0, "R1", "responses outstanding", 64'(sb.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule